// File: doc/BRIEF.md
# ROM-Driven Serial Trace Transmitter

This block is a transmit-only serial line for debug tracing. A controller writes a message number into the block. The block then shifts out a fixed eight-character message, taken from a 64-entry character table that is built into the RTL. Each character frame lasts sixteen baud ticks. A frame holds a start bit, eight data bits sent LSB first, and seven mark slots, so the line gets generous stop time. The block does not generate its own baud rate. It advances only on an external single-cycle tick.

Any table byte with its top bit set is a placeholder. Its low four bits pick one of sixteen external 4-bit tap inputs, and the live nibble is sent as an uppercase ASCII hex digit in place of the byte. This lets fixed text and live hardware values share one trace line. A controller waits for `ready`, writes the message number, and may not start another trace until `ready` returns.

The control is a two-state machine. In `ST_IDLE` the line is held at mark and `ready` is high. The transition START (a nonzero write while idle) moves the machine to `ST_SEND`. In `ST_SEND` a 7-bit tick counter sequences the slots. The transition FINISH (a tick while the counter is at 127) returns the machine to `ST_IDLE`.

Top module: `trace_serializer`

## Requirements
- R1: After reset, `ready` is 1 and `txd` is 1.
- R2: While `ready` is 1, `txd` stays 1. A write of message number 0 is ignored, so `ready` and `txd` remain 1.
- R3: A write of a nonzero message number while `ready` is 1 starts a message. In the next cycle `ready` is 0 and `txd` is 0, which is the start bit of character 0.
- R4: Each character frame spans 16 ticks. Slot 0 is 0, slots 1 to 8 carry the character bits LSB first, and slots 9 to 15 are 1. `txd` changes only in the cycle after a tick edge.
- R5: A message sends characters 0 to 7 in order over 128 ticks. One cycle after the 128th tick edge, `ready` is 1 again.
- R6: Byte p (0..7) of entry e is 0x41 + ((e + p) mod 26) for p < 6. Byte 6 is 0x80 | (e mod 16). Byte 7 is 0x80 | ((e + 8) mod 16).
- R7: A byte with bit 7 set is replaced by tap k, where k is the byte's low 4 bits and tap k occupies `tap_nibbles[4k+3:4k]`. The nibble is sent as '0'-'9' (0x30-0x39) or 'A'-'F' (0x41-0x46).
- R8: Tap values are captured when a character frame begins. For character 0 this is the write edge. For later characters it is the tick edge that ends the previous frame. Changes to the taps after that point do not alter the character.
- R9: A write during a message is ignored. The message in progress continues unchanged, and `ready` stays 0 until that message ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per serial bit slot |
| wr_en | input | 1 | Message-number write strobe |
| wr_idx | input | 6 | Message number to send (0 means none) |
| tap_nibbles | input | 64 | Sixteen packed 4-bit live values |
| ready | output | 1 | High when a new message may be written |
| txd | output | 1 | Serial output, idle high |

## Verification
The start bit appears in the cycle after the write edge. Each later slot appears in the cycle after the tick edge that advances the counter. `ready` returns one cycle after the 128th tick edge. The bench drives writes and tick pulses at falling edges and samples `txd` and `ready` at the falling edge after each rising edge, so every sample sees exactly one register update. It decodes each 16-slot frame and compares the frame with a character computed from the table formula and from a snapshot of the taps taken at the edge where the frame begins. Random tap changes in the middle of a frame, and writes made while busy, must leave the decoded text unchanged.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } trc_state_e;

    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        logic [7:0] r;
        if (n < 4'd10) r = 8'h30 + {4'h0, n};
        else           r = 8'h37 + {4'h0, n};
        return r;
    endfunction

endpackage

// File: rtl/trc_msg_rom.sv
module trc_msg_rom #(
    parameter int IDX_W = 6,
    parameter int POS_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [POS_W-1:0] pos,
    output logic [7:0]       code
);
    localparam int ESC_A = 6;
    localparam int ESC_B = 7;

    logic [7:0] sum;
    logic [7:0] letter;

    always_comb begin
        sum    = 8'(idx) + 8'(pos);
        letter = 8'h41 + (sum % 8'd26);
        if (pos == POS_W'(ESC_A))
            code = {4'h8, idx[3:0]};
        else if (pos == POS_W'(ESC_B))
            code = {4'h8, idx[3:0] + 4'd8};
        else
            code = letter;
    end
endmodule

// File: rtl/trc_char_sel.sv
module trc_char_sel #(
    parameter int TAP_CNT = 16,
    parameter int NIB_W   = 4
) (
    input  logic [7:0]               code,
    input  logic [TAP_CNT*NIB_W-1:0] taps,
    output logic [7:0]               ch
);
    import trc_pkg::*;
    localparam int SEL_W = $clog2(TAP_CNT);

    logic [NIB_W-1:0] tap_arr [TAP_CNT];

    for (genvar k = 0; k < TAP_CNT; k++) begin : g_unpack
        assign tap_arr[k] = taps[k*NIB_W +: NIB_W];
    end

    always_comb begin
        if (code[7]) ch = nib_to_ascii(tap_arr[code[SEL_W-1:0]]);
        else         ch = code;
    end
endmodule

// File: rtl/trc_frame_seq.sv
module trc_frame_seq #(
    parameter int IDX_W  = 6,
    parameter int POS_W  = 3,
    parameter int SLOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       next_ch,
    output logic [IDX_W-1:0] rom_idx,
    output logic [POS_W-1:0] rom_pos,
    output logic             ready,
    output logic             txd
);
    import trc_pkg::*;
    localparam int CNT_W = POS_W + SLOT_W;

    trc_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        char_q;
    logic              start, last, frame_end;
    logic [SLOT_W-1:0] slot, bit_sel;
    logic [POS_W-1:0]  pos_cur;

    assign start     = (state_q == ST_IDLE) && wr_en && (wr_idx != '0);
    assign last      = (state_q == ST_SEND) && baud_tick && (cnt_q == '1);
    assign slot      = cnt_q[SLOT_W-1:0];
    assign frame_end = baud_tick && (slot == '1);
    assign pos_cur   = cnt_q[CNT_W-1:SLOT_W];
    assign bit_sel   = slot - SLOT_W'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (last)  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            char_q  <= 8'hFF;
        end else begin
            state_q <= state_d;
            if (start) begin
                cnt_q  <= '0;
                idx_q  <= wr_idx;
                char_q <= next_ch;
            end else if (state_q == ST_SEND && baud_tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (last)           idx_q  <= '0;
                else if (frame_end) char_q <= next_ch;
            end
        end
    end

    always_comb begin
        rom_idx = (state_q == ST_IDLE) ? wr_idx : idx_q;
        rom_pos = (state_q == ST_IDLE) ? '0 : pos_cur + POS_W'(1);
        ready   = (state_q == ST_IDLE);
        txd     = 1'b1;
        unique case (state_q)
            ST_IDLE: txd = 1'b1;
            ST_SEND: begin
                if (slot == '0)                txd = 1'b0;
                else if (slot <= SLOT_W'(8))   txd = char_q[bit_sel[2:0]];
                else                           txd = 1'b1;
            end
        endcase
    end

    // R3
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!ready && !txd));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(wr_en && wr_idx != '0)) |=> (ready && txd));
    // R4
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !baud_tick) |=> $stable(txd));
    // R5
    msg_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (ready && txd));
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !last) |=> (!ready && $stable(idx_q)));
endmodule

// File: rtl/trace_serializer.sv
module trace_serializer #(
    parameter int IDX_W    = 6,
    parameter int CHAR_CNT = 8,
    parameter int TAP_CNT  = 16,
    parameter int NIB_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     baud_tick,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [TAP_CNT*NIB_W-1:0] tap_nibbles,
    output logic                     ready,
    output logic                     txd
);
    localparam int POS_W  = $clog2(CHAR_CNT);
    localparam int SLOT_W = 4;

    logic [IDX_W-1:0] rom_idx;
    logic [POS_W-1:0] rom_pos;
    logic [7:0]       rom_code;
    logic [7:0]       next_ch;

    trc_msg_rom #(.IDX_W(IDX_W), .POS_W(POS_W)) u_rom (
        .idx  (rom_idx),
        .pos  (rom_pos),
        .code (rom_code)
    );

    trc_char_sel #(.TAP_CNT(TAP_CNT), .NIB_W(NIB_W)) u_sel (
        .code (rom_code),
        .taps (tap_nibbles),
        .ch   (next_ch)
    );

    trc_frame_seq #(.IDX_W(IDX_W), .POS_W(POS_W), .SLOT_W(SLOT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .next_ch   (next_ch),
        .rom_idx   (rom_idx),
        .rom_pos   (rom_pos),
        .ready     (ready),
        .txd       (txd)
    );

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> txd);
endmodule

// File: tb/tb_trace_serializer.sv
module tb_trace_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] tap_nibbles = '0;
    logic        ready, txd;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    trace_serializer dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_idx(wr_idx), .tap_nibbles(tap_nibbles), .ready(ready), .txd(txd)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [7:0] exp_char(input int e, input int p, input logic [63:0] tv);
        logic [7:0] code;
        logic [3:0] n;
        if (p < 6) code = 8'(8'h41 + ((e + p) % 26));
        else if (p == 6) code = 8'(8'h80 | (e % 16));
        else code = 8'(8'h80 | ((e + 8) % 16));
        if (code[7]) begin
            n = tv[int'(code[3:0])*4 +: 4];
            return (n < 10) ? 8'(8'h30 + n) : 8'(8'h41 + n - 10);
        end
        return code;
    endfunction

    task automatic tick();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic run_msg(input int idx, input bit busy_wr, input bit rnd_taps);
        logic [63:0] snap, snap_next;
        logic [15:0] fr;
        logic [7:0]  ec;
        wr_en = 1'b1; wr_idx = 6'(idx); snap = tap_nibbles;
        @(negedge clk);
        wr_en = 1'b0;
        chk(ready == 1'b0 && txd == 1'b0, "R3 start", {ready, txd}, 0);
        snap_next = snap;
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 16; s++) begin
                fr[s] = txd;
                if (s == 5 && rnd_taps) tap_nibbles = {$urandom, $urandom};
                if (s == 15) snap_next = tap_nibbles;
                if (busy_wr && c == 2 && s == 3) begin
                    wr_en = 1'b1; wr_idx = 6'(idx ^ 6'h15);
                    @(negedge clk);
                    wr_en = 1'b0;
                    chk(ready == 1'b0 && txd == fr[s], "R9 busy write", {ready, txd}, {1'b0, fr[s]});
                end
                tick();
            end
            ec = exp_char(idx, c, snap);
            chk(fr[0] == 1'b0 && fr[15:9] == 7'h7F, "R4 frame", fr, {7'h7F, ec, 1'b0});
            if (c >= 6) chk(fr[8:1] == ec, "R7 R8 tap digit", fr[8:1], ec);
            else        chk(fr[8:1] == ec, "R6 R5 text char", fr[8:1], ec);
            snap = snap_next;
        end
        chk(ready == 1'b1 && txd == 1'b1, "R5 ready after 128 ticks", {ready, txd}, 2'b11);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1 && txd == 1'b1, "R1 reset", {ready, txd}, 2'b11);

        // R2: write of zero ignored
        wr_en = 1'b1; wr_idx = 6'd0;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        chk(ready == 1'b1 && txd == 1'b1, "R2 zero write", {ready, txd}, 2'b11);

        tap_nibbles = 64'hFEDC_BA98_7654_3210;
        run_msg(1, 1'b0, 1'b0);
        run_msg(63, 1'b0, 1'b0);
        tap_nibbles = '1;
        run_msg(8, 1'b1, 1'b0);
        run_msg(25, 1'b0, 1'b1);
        for (int m = 0; m < 10; m++) begin
            tap_nibbles = {$urandom, $urandom};
            run_msg(1 + int'($urandom % 63), (m % 3) == 0, 1'b1);
        end
        report();
        $finish;
    end
endmodule